// File: doc/BRIEF.md
# ISDN S/T Terminal Layer-1 Activation Controller

This block is the layer-1 activation state machine for the terminal side of an ISDN basic-rate S/T interface. A receiver front end reports which INFO signal it decodes. The controller answers with the INFO type the line transmitter should send. It produces a registered indication code, and a one-cycle strobe marks each change of that code, so the upstream controller reads exactly one code per change. The normal path goes from deactivated to synchronized when INFO2 arrives. From there it goes to activated once INFO4 has been present for a dwell of `DWELL_TICKS` timebase ticks. With the default of 4 ticks at 125 µs each, the dwell is about 0.5 ms.

In line-termination-terminal (LT-T) mode, the activated state also watches the measured clock phase wander. When the wander passes the threshold, the controller spends one dwell period in a slip state so the elastic buffer can resynchronize. The threshold is 50 µs, or 25 µs when the tighter setting is selected. Commands from the control channel move the block from any state. A reset command goes to deactivated. A loop command closes an internal loop, which sends the transmitter output back to the receiver while INFO0 goes out on the line. Two test commands drive alternating-polarity pulse patterns: single pulses, or a continuous pulse train. The pulse rates are set in clock cycles by parameters.

Top module: `st_l1_act_ctrl`

## Requirements
- R1: After reset the state is deactivated: `tx_info`=0 (INFO0), `loop_en`=0, `ind_code`=0, `ind_stb`=0, `line_mark`=0.
- R2: In deactivated, `rx_info`=1 (INFO2) moves the block to synchronized (`ind_code`=1) at the next edge. In synchronized and activated, `tx_info`=1 (INFO3).
- R3: In synchronized, the block moves to activated (`ind_code`=2) on the `DWELL_TICKS`-th `tick` seen while `rx_info`=2 (INFO4) is held. Any cycle without INFO4 restarts the tick count.
- R4: In activated, `rx_info`=0 (INFO0) returns the block to deactivated. Any other code except INFO4 returns it to synchronized. In synchronized, INFO0 returns it to deactivated.
- R5: In activated with `lt_t_mode`=1, a `wander` strictly greater than the threshold enters the slip state (`ind_code`=3). The threshold is 50, or 25 when `tight_wander`=1. With `lt_t_mode`=0 the slip state is never entered.
- R6: The slip state returns to activated on its `DWELL_TICKS`-th tick. It ignores `rx_info`.
- R7: Command 1 (close loop) from any state gives the loop-pending state (`ind_code`=4), with `loop_en`=1 and `tx_info`=0.
- R8: In loop-pending, `rx_info`=3 (looped INFO3 locked) gives loop-activated. `ind_code` is 5, or 6 while `line_awake`=1, following `line_awake` each cycle.
- R9: Command 2 selects test 1 (`tx_info`=2, `ind_code`=7). `line_mark` gives one-cycle pulses exactly `TM1_PERIOD` cycles apart, and `line_pol` alternates from pulse to pulse.
- R10: Command 3 selects test 2 (`tx_info`=3, `ind_code`=7). From the second cycle on, `line_mark` stays high, and `line_pol` flips every `TM2_HALF` cycles.
- R11: Command 0 returns the block to deactivated from any state. Command codes 4 to 15 have no effect.
- R12: `ind_stb` is high for exactly the cycles in which `ind_code` has just taken a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_info | input | 2 | Decoded receive signal: 0 INFO0, 1 INFO2, 2 INFO4, 3 looped INFO3 |
| cmd_valid | input | 1 | Command present this cycle |
| cmd | input | 4 | Command code: 0 reset, 1 close loop, 2 test 1, 3 test 2 |
| tick | input | 1 | One-cycle timebase pulse |
| lt_t_mode | input | 1 | Enables slip handling |
| tight_wander | input | 1 | Selects the 25 µs wander threshold |
| wander | input | WANDER_W | Measured phase wander in µs |
| line_awake | input | 1 | Line awake detector output |
| tx_info | output | 2 | Transmit: 0 INFO0, 1 INFO3, 2 test 1 pulses, 3 test 2 pulses |
| loop_en | output | 1 | Internal loop closed |
| ind_code | output | 3 | Registered indication code |
| ind_stb | output | 1 | Indication changed this cycle |
| line_mark | output | 1 | Test pulse present |
| line_pol | output | 1 | Test pulse polarity |

## Verification
The assertions check the following on every cycle:
- A reset or loop command takes effect one edge later.
- The strobe marks a changed indication and only that.
- Activation is entered only on a tick taken while INFO4 is present.
- Slip is entered only from activated, and only in LT-T mode.
- Test 1 never produces two marks in a row, and test 2 keeps its mark high.
- The dwell counter stays below its limit.

Some behaviour only the bench scenarios can show. The dwell timer restarts when INFO4 drops. A wander exactly at the threshold does not slip. Unknown commands leave the state alone. The two test patterns keep their exact pulse spacing and polarity alternation.

// File: rtl/st_l1_pkg.sv
package st_l1_pkg;

   typedef enum logic [1:0] {
      RX_INFO0 = 2'd0,
      RX_INFO2 = 2'd1,
      RX_INFO4 = 2'd2,
      RX_LOOP3 = 2'd3
   } rx_info_e;

   typedef enum logic [1:0] {
      TX_INFO0 = 2'd0,
      TX_INFO3 = 2'd1,
      TX_TEST1 = 2'd2,
      TX_TEST2 = 2'd3
   } tx_info_e;

   typedef enum logic [2:0] {
      ST_DEACT    = 3'd0,
      ST_SYNC     = 3'd1,
      ST_ACT      = 3'd2,
      ST_SLIP     = 3'd3,
      ST_LOOP_PND = 3'd4,
      ST_LOOP_ACT = 3'd5,
      ST_TEST1    = 3'd6,
      ST_TEST2    = 3'd7
   } l1_state_e;

   typedef enum logic [2:0] {
      IND_DEACT    = 3'd0,
      IND_SYNC     = 3'd1,
      IND_ACT      = 3'd2,
      IND_SLIP     = 3'd3,
      IND_LOOP_PND = 3'd4,
      IND_LOOP_ACT = 3'd5,
      IND_LINE_SIG = 3'd6,
      IND_TEST     = 3'd7
   } ind_e;

   localparam logic [3:0] CMD_RESET = 4'd0;
   localparam logic [3:0] CMD_LOOP  = 4'd1;
   localparam logic [3:0] CMD_TEST1 = 4'd2;
   localparam logic [3:0] CMD_TEST2 = 4'd3;

   function automatic tx_info_e tx_of(input l1_state_e s);
      unique case (s)
         ST_SYNC, ST_ACT, ST_SLIP: tx_of = TX_INFO3;
         ST_TEST1:                 tx_of = TX_TEST1;
         ST_TEST2:                 tx_of = TX_TEST2;
         default:                  tx_of = TX_INFO0;
      endcase
   endfunction

   function automatic ind_e ind_of(input l1_state_e s, input logic awake);
      unique case (s)
         ST_DEACT:    ind_of = IND_DEACT;
         ST_SYNC:     ind_of = IND_SYNC;
         ST_ACT:      ind_of = IND_ACT;
         ST_SLIP:     ind_of = IND_SLIP;
         ST_LOOP_PND: ind_of = IND_LOOP_PND;
         ST_LOOP_ACT: ind_of = awake ? IND_LINE_SIG : IND_LOOP_ACT;
         default:     ind_of = IND_TEST;
      endcase
   endfunction

endpackage

// File: rtl/st_l1_dwell_timer.sv
module st_l1_dwell_timer #(
   parameter int DWELL_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic done
);
   localparam int CW = (DWELL_TICKS > 1) ? $clog2(DWELL_TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(DWELL_TICKS - 1);

   generate
      if (DWELL_TICKS < 1) begin : g_bad_dwell
         $error("st_l1_dwell_timer: DWELL_TICKS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign done = run && tick && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || done) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3 / R6: the dwell count never passes its last value
   a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R3: a stopped timer always restarts from zero
   a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt_q == '0);

endmodule

// File: rtl/st_l1_slip_det.sv
module st_l1_slip_det #(
   parameter int WANDER_W  = 8,
   parameter int THR_LOOSE = 50,
   parameter int THR_TIGHT = 25,
   parameter bit SLIP_REG  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [WANDER_W-1:0] wander,
   input  logic                tight,
   output logic                over
);
   localparam logic [WANDER_W-1:0] LIM_LOOSE = WANDER_W'(THR_LOOSE);
   localparam logic [WANDER_W-1:0] LIM_TIGHT = WANDER_W'(THR_TIGHT);

   generate
      if (THR_TIGHT >= THR_LOOSE) begin : g_bad_order
         $error("st_l1_slip_det: tight threshold must be below loose threshold");
      end
      if (THR_LOOSE >= (1 << WANDER_W)) begin : g_bad_width
         $error("st_l1_slip_det: WANDER_W too narrow for THR_LOOSE");
      end
   endgenerate

   logic [WANDER_W-1:0] limit;
   logic                over_c;

   assign limit  = tight ? LIM_TIGHT : LIM_LOOSE;
   assign over_c = wander > limit;

   generate
      if (SLIP_REG) begin : g_reg
         logic over_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) over_q <= 1'b0;
            else        over_q <= over_c;
         end
         assign over = over_q;
      end else begin : g_comb
         assign over = over_c;
      end
   endgenerate

endmodule

// File: rtl/st_l1_test_pulse.sv
module st_l1_test_pulse #(
   parameter int TM1_PERIOD = 8,
   parameter int TM2_HALF   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tm1,
   input  logic tm2,
   output logic mark,
   output logic pol
);
   localparam int SPAN = (TM1_PERIOD > TM2_HALF) ? TM1_PERIOD : TM2_HALF;
   localparam int CW   = (SPAN > 1) ? $clog2(SPAN) : 1;
   localparam logic [CW-1:0] P1_LAST = CW'(TM1_PERIOD - 1);
   localparam logic [CW-1:0] H2_LAST = CW'(TM2_HALF - 1);

   generate
      if (TM1_PERIOD < 2) begin : g_bad_p1
         $error("st_l1_test_pulse: TM1_PERIOD must be at least 2");
      end
      if (TM2_HALF < 1) begin : g_bad_h2
         $error("st_l1_test_pulse: TM2_HALF must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [1:0]    mode_q;
   logic [1:0]    mode;

   assign mode = {tm2, tm1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         mode_q <= 2'b00;
         mark   <= 1'b0;
         pol    <= 1'b0;
      end else begin
         mode_q <= mode;
         if (mode != mode_q || mode == 2'b00) begin
            cnt_q <= '0;
            mark  <= 1'b0;
            pol   <= 1'b0;
         end else if (tm1) begin
            if (cnt_q == P1_LAST) begin
               cnt_q <= '0;
               mark  <= 1'b1;
               pol   <= ~pol;
            end else begin
               cnt_q <= cnt_q + 1'b1;
               mark  <= 1'b0;
            end
         end else begin
            mark <= 1'b1;
            if (cnt_q == H2_LAST) begin
               cnt_q <= '0;
               pol   <= ~pol;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R9: test 1 pulses are single cycles
   a_r9_single_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (tm1 && mark) |=> !mark);

   // R10: test 2 holds its mark once settled
   a_r10_continuous: assert property (@(posedge clk) disable iff (!rst_n)
      (tm2 && $past(tm2) && $past(tm2, 2)) |-> mark);

endmodule

// File: rtl/st_l1_act_ctrl.sv
module st_l1_act_ctrl
   import st_l1_pkg::*;
#(
   parameter int DWELL_TICKS = 4,
   parameter int WANDER_W    = 8,
   parameter int THR_LOOSE   = 50,
   parameter int THR_TIGHT   = 25,
   parameter bit SLIP_REG    = 1'b0,
   parameter int TM1_PERIOD  = 8,
   parameter int TM2_HALF    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          rx_info,
   input  logic                cmd_valid,
   input  logic [3:0]          cmd,
   input  logic                tick,
   input  logic                lt_t_mode,
   input  logic                tight_wander,
   input  logic [WANDER_W-1:0] wander,
   input  logic                line_awake,
   output logic [1:0]          tx_info,
   output logic                loop_en,
   output logic [2:0]          ind_code,
   output logic                ind_stb,
   output logic                line_mark,
   output logic                line_pol
);

   l1_state_e state_q, state_d;
   ind_e      ind_q, ind_d;
   rx_info_e  rx;
   logic      dwell_run, dwell_done, slip_over;

   assign rx = rx_info_e'(rx_info);

   assign dwell_run = (state_q == ST_SYNC && rx == RX_INFO4) || (state_q == ST_SLIP);

   st_l1_dwell_timer #(.DWELL_TICKS(DWELL_TICKS)) u_dwell (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (dwell_run),
      .tick (tick),
      .done (dwell_done)
   );

   st_l1_slip_det #(
      .WANDER_W (WANDER_W),
      .THR_LOOSE(THR_LOOSE),
      .THR_TIGHT(THR_TIGHT),
      .SLIP_REG (SLIP_REG)
   ) u_slip (
      .clk   (clk),
      .rst_n (rst_n),
      .wander(wander),
      .tight (tight_wander),
      .over  (slip_over)
   );

   st_l1_test_pulse #(
      .TM1_PERIOD(TM1_PERIOD),
      .TM2_HALF  (TM2_HALF)
   ) u_pulse (
      .clk  (clk),
      .rst_n(rst_n),
      .tm1  (state_q == ST_TEST1),
      .tm2  (state_q == ST_TEST2),
      .mark (line_mark),
      .pol  (line_pol)
   );

   always_comb begin
      state_d = state_q;
      if (cmd_valid && cmd == CMD_RESET) begin
         state_d = ST_DEACT;
      end else if (cmd_valid && cmd == CMD_LOOP) begin
         state_d = ST_LOOP_PND;
      end else if (cmd_valid && cmd == CMD_TEST1) begin
         state_d = ST_TEST1;
      end else if (cmd_valid && cmd == CMD_TEST2) begin
         state_d = ST_TEST2;
      end else begin
         unique case (state_q)
            ST_DEACT: begin
               if (rx == RX_INFO2) state_d = ST_SYNC;
            end
            ST_SYNC: begin
               if (rx == RX_INFO0)  state_d = ST_DEACT;
               else if (dwell_done) state_d = ST_ACT;
            end
            ST_ACT: begin
               if (rx == RX_INFO0)                state_d = ST_DEACT;
               else if (rx != RX_INFO4)           state_d = ST_SYNC;
               else if (lt_t_mode && slip_over)   state_d = ST_SLIP;
            end
            ST_SLIP: begin
               if (dwell_done) state_d = ST_ACT;
            end
            ST_LOOP_PND: begin
               if (rx == RX_LOOP3) state_d = ST_LOOP_ACT;
            end
            default: state_d = state_q;
         endcase
      end
   end

   assign ind_d = ind_of(state_d, line_awake);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_DEACT;
         ind_q   <= IND_DEACT;
         ind_stb <= 1'b0;
      end else begin
         state_q <= state_d;
         ind_q   <= ind_d;
         ind_stb <= (ind_d != ind_q);
      end
   end

   assign ind_code = ind_q;
   assign tx_info  = tx_of(state_q);
   assign loop_en  = (state_q == ST_LOOP_PND) || (state_q == ST_LOOP_ACT);

   // R2: synchronized is reached from deactivated only on INFO2 or by no command
   a_r2_sync_on_info2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SYNC && $past(state_q) == ST_DEACT) |-> $past(rx_info) == 2'd1);

   // R3: activation from synchronized only on a tick with INFO4 present
   a_r3_act_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACT && $past(state_q) == ST_SYNC) |-> ($past(tick) && $past(rx_info) == 2'd2));

   // R5: slip entered only from activated in LT-T mode
   a_r5_slip_ltt_only: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLIP && $past(state_q) != ST_SLIP) |-> ($past(lt_t_mode) && $past(state_q) == ST_ACT));

   // R7: loop command closes the internal loop and quiets the line
   a_r7_loop_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd == CMD_LOOP) |=> (loop_en && tx_info == 2'd0));

   // R11: reset command always lands in deactivated
   a_r11_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd == CMD_RESET) |=> (ind_code == 3'd0 && tx_info == 2'd0));

   // R12: strobe exactly on a changed indication
   a_r12_stb_change: assert property (@(posedge clk) disable iff (!rst_n)
      ind_stb |-> ind_code != $past(ind_code));
   a_r12_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !ind_stb |-> $stable(ind_code));

endmodule

// File: tb/sim_st_l1_act_ctrl.sv
module sim_st_l1_act_ctrl;

   localparam int DWELL = 4;
   localparam int WW    = 8;
   localparam int P1    = 8;
   localparam int H2    = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    rx_info = 2'd0;
   logic          cmd_valid = 1'b0;
   logic [3:0]    cmd = 4'd0;
   logic          tick = 1'b0;
   logic          lt_t_mode = 1'b0;
   logic          tight_wander = 1'b0;
   logic [WW-1:0] wander = '0;
   logic          line_awake = 1'b0;
   logic [1:0]    tx_info;
   logic          loop_en;
   logic [2:0]    ind_code;
   logic          ind_stb;
   logic          line_mark;
   logic          line_pol;

   int vectors = 0;
   int miscompares = 0;
   int exp_q[$];
   string tag_q[$];

   always #5 clk = ~clk;

   st_l1_act_ctrl #(
      .DWELL_TICKS(DWELL), .WANDER_W(WW), .THR_LOOSE(50), .THR_TIGHT(25),
      .SLIP_REG(1'b0), .TM1_PERIOD(P1), .TM2_HALF(H2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .rx_info(rx_info), .cmd_valid(cmd_valid), .cmd(cmd),
      .tick(tick), .lt_t_mode(lt_t_mode), .tight_wander(tight_wander), .wander(wander),
      .line_awake(line_awake), .tx_info(tx_info), .loop_en(loop_en), .ind_code(ind_code),
      .ind_stb(ind_stb), .line_mark(line_mark), .line_pol(line_pol)
   );

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_ind(input int code, input string tag);
      exp_q.push_back(code);
      tag_q.push_back(tag);
   endtask

   task automatic send_cmd(input logic [3:0] c);
      cmd_valid = 1'b1;
      cmd = c;
      cyc(1);
      cmd_valid = 1'b0;
      cmd = 4'd0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         cyc(1);
         tick = 1'b0;
         cyc(1);
      end
   endtask

   task automatic activate(input string tag);
      rx_info = 2'd1;
      expect_ind(1, tag);
      cyc(1);
      rx_info = 2'd2;
      cyc(1);
      expect_ind(2, tag);
      ticks(DWELL);
   endtask

   // monitor: pops one expected indication per strobe
   always @(negedge clk) begin
      if (rst_n && ind_stb) begin
         if (exp_q.size() == 0) begin
            chk("R12 unexpected strobe", ind_code, -1);
         end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, ind_code, e);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      chk("watchdog expired", 1, 0);
      summary();
      $finish;
   end

   initial begin
      cyc(3);
      // R1 reset state
      chk("R1 tx_info", tx_info, 0);
      chk("R1 loop_en", loop_en, 0);
      chk("R1 ind_code", ind_code, 0);
      chk("R1 ind_stb", ind_stb, 0);
      chk("R1 line_mark", line_mark, 0);
      rst_n = 1'b1;
      cyc(2);

      // R2 INFO2 -> synchronized
      rx_info = 2'd1;
      expect_ind(1, "R2 sync on INFO2");
      cyc(1);
      chk("R2 tx INFO3", tx_info, 1);

      // R3 dwell with restart
      rx_info = 2'd2;
      cyc(1);
      ticks(2);
      rx_info = 2'd1;
      cyc(1);
      rx_info = 2'd2;
      cyc(1);
      ticks(DWELL - 1);
      chk("R3 restart keeps sync", ind_code, 1);
      expect_ind(2, "R3 activated after dwell");
      ticks(1);
      chk("R3 activated code", ind_code, 2);
      chk("R2 tx INFO3 when active", tx_info, 1);

      // R5 TE mode ignores wander, equal value does not slip
      lt_t_mode = 1'b0;
      wander = 8'd100;
      cyc(2);
      chk("R5 no slip in TE mode", ind_code, 2);
      lt_t_mode = 1'b1;
      wander = 8'd50;
      cyc(2);
      chk("R5 wander equal threshold no slip", ind_code, 2);
      wander = 8'd51;
      expect_ind(3, "R5 slip above loose threshold");
      cyc(1);
      wander = 8'd0;
      rx_info = 2'd1;
      cyc(1);
      chk("R6 slip ignores rx", ind_code, 3);
      rx_info = 2'd2;

      // R6 slip dwell
      ticks(DWELL - 1);
      chk("R6 still slip", ind_code, 3);
      expect_ind(2, "R6 back to activated");
      ticks(1);

      // R4 loss of INFO4 and INFO0
      rx_info = 2'd1;
      expect_ind(1, "R4 INFO2 back to sync");
      cyc(1);
      rx_info = 2'd2;
      cyc(1);
      expect_ind(2, "R4 reactivate");
      ticks(DWELL);
      rx_info = 2'd0;
      expect_ind(0, "R4 INFO0 to deactivated");
      cyc(2);

      // R5 tight threshold, R11 unknown command and reset
      activate("R5 activate again");
      tight_wander = 1'b1;
      wander = 8'd26;
      expect_ind(3, "R5 slip above tight threshold");
      cyc(1);
      wander = 8'd0;
      send_cmd(4'd9);
      cyc(1);
      chk("R11 unknown cmd ignored", ind_code, 3);
      chk("R11 unknown cmd no strobe", ind_stb, 0);
      expect_ind(0, "R11 reset cmd from slip");
      send_cmd(4'd0);
      chk("R11 tx INFO0 after reset", tx_info, 0);
      rx_info = 2'd0;
      cyc(1);

      // R7 / R8 loop
      expect_ind(4, "R7 loop pending");
      send_cmd(4'd1);
      chk("R7 loop_en", loop_en, 1);
      chk("R7 line INFO0", tx_info, 0);
      rx_info = 2'd3;
      expect_ind(5, "R8 loop activated");
      cyc(2);
      line_awake = 1'b1;
      expect_ind(6, "R8 signal on line");
      cyc(2);
      line_awake = 1'b0;
      expect_ind(5, "R8 signal gone");
      cyc(2);
      rx_info = 2'd0;

      // R9 test 1
      expect_ind(7, "R9 test 1 indication");
      send_cmd(4'd2);
      chk("R9 tx code", tx_info, 2);
      chk("R9 loop opened", loop_en, 0);
      begin
         int last = -1;
         int nmk = 0;
         logic lp = 1'b0;
         for (int i = 0; i < 6 * P1; i++) begin
            if (line_mark) begin
               if (last >= 0) begin
                  chk("R9 pulse spacing", i - last, P1);
                  chk("R9 polarity alternates", line_pol, !lp);
               end
               lp = line_pol;
               last = i;
               nmk++;
            end
            cyc(1);
         end
         chk("R9 pulse count", nmk, 5);
      end

      // R10 test 2 (same indication, no strobe expected)
      send_cmd(4'd3);
      chk("R10 tx code", tx_info, 3);
      chk("R10 indication kept", ind_code, 7);
      cyc(2);
      begin
         int gaps = 0;
         int lows = 0;
         int last = -1;
         logic lp = line_pol;
         for (int i = 0; i < 8 * H2; i++) begin
            if (!line_mark) lows++;
            if (line_pol != lp) begin
               if (last >= 0) chk("R10 toggle interval", i - last, H2);
               last = i;
               gaps++;
            end
            lp = line_pol;
            cyc(1);
         end
         chk("R10 mark held high", lows, 0);
         chk("R10 toggles seen", gaps >= 6, 1);
      end

      // R11 reset from test
      expect_ind(0, "R11 reset cmd from test");
      send_cmd(4'd0);
      cyc(2);
      chk("R11 mark cleared", line_mark, 0);
      chk("R11 tx INFO0", tx_info, 0);

      cyc(2);
      chk("R12 all expected indications seen", exp_q.size(), 0);
      summary();
      $finish;
   end

endmodule